// File: doc/BRIEF.md
# Multichannel Audio Frame Serializer (TDM/PCM and I2S-style)

This block drives an audio link as its master. It makes the bit clock, the frame sync and the serial data line. Parallel samples arrive through a valid/ready input, one sample per channel slot, and leave MSB first. It runs from an internal clock at twice the bit-clock rate, so each bit lasts two internal cycles. Data can therefore be launched on either bit-clock edge.

Four framings are offered, selected by `cfg_fmt`:
- **TDM/PCM (0):** slot width, frame width, channel count, sync pulse width and data offset are all free.
- **I2S normal (1):** two channels, each half a frame long, with the left channel marked by a low sync and data one bit late.
- **Left-justified (2):** two channels with the left channel marked by a high sync and no delay.
- **Right-justified (3):** as left-justified, but each sample ends on the last bit of its half.

Configuration is taken when `enable` rises. A link is started by setting the configuration, raising `enable` and then serving `s_ready` pulses.

The slot sequencer is a four-state machine:
- **ST_IDLE:** link stopped.
- **ST_PRIME:** fetches the first sample, for one cycle.
- **ST_ACTIVE:** serializing a channel slot.
- **ST_PAD:** idle bits after the last channel.

Its transitions are:
- IDLE→PRIME when enable rises.
- PRIME→ACTIVE unconditionally.
- ACTIVE→ACTIVE at a slot boundary that starts another served slot.
- ACTIVE→PAD at a slot boundary past the last channel.
- PAD→ACTIVE at the frame boundary.
- Any state →IDLE when enable falls.

Top module: `tdm_audio_tx`

## Requirements
- R1: After reset, and on the cycle after `enable` falls, the outputs rest at their idle levels: `bclk` = `cfg_bclk_inv`, `fsync` = `cfg_fsync_inv`, `sdata` = 0, `s_ready` = 0 and `underrun` = 0.
- R2: While running, `bclk` toggles on every internal clock cycle. Without inversion it is low in the first half of each bit and high in the second; `cfg_bclk_inv` = 1 inverts it.
- R3: In TDM/PCM framing a frame is `cfg_frame_bits` bits long (32 to 512). `fsync` is high for its first `cfg_fsync_bits` bits and low for the rest, and `cfg_fsync_inv` = 1 inverts it.
- R4: In TDM/PCM framing with offset 0, slot k starts at bit k×`cfg_slot_bits` (slot width 16 to 32). It carries the k-th sample of the frame MSB first, taken from the left-aligned `s_data` word whose bit 31 is the MSB. Bits after the first `cfg_sample_bits` of a slot are 0.
- R5: Frame bits beyond the last served channel slot carry 0.
- R6: `cfg_shift` (0 to 4) delays the TDM/PCM data stream against the bit clock and sync by that many half bit periods.
- R7: I2S normal framing (`cfg_fmt` = 1) sends two channels with slot = frame/2. `fsync` is low for the first half of the frame (left) and high for the second, and the data is one bit period late. The slot, channel, sync-width and offset inputs are ignored in this framing.
- R8: Left-justified framing (`cfg_fmt` = 2) sends two half-frame channels with `fsync` high for the first half and the MSB on the first bit of each half.
- R9: Right-justified framing (`cfg_fmt` = 3) matches left-justified framing, except that each sample's LSB falls on the last bit of its half-frame.
- R10: `s_ready` is high for exactly one cycle per served slot, and never in two consecutive cycles. It rises in the start-up priming cycle, or otherwise in the second half of the bit before the slot begins. A sample is taken when `s_valid` and `s_ready` are both high.
- R11: If `s_valid` is low while `s_ready` is high, that slot carries zeros and `underrun` goes high. It stays high until `enable` falls.
- R12: Configuration inputs are captured when `enable` rises; changes made while running have no effect.
- R13: Channels whose slot would start past the frame end are never served and get no `s_ready` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bit-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Starts (rising) and stops (falling) the link |
| cfg_fmt | input | 2 | Framing: 0 TDM/PCM, 1 I2S normal, 2 left-justified, 3 right-justified |
| cfg_frame_bits | input | 10 | Bits per frame |
| cfg_slot_bits | input | 6 | Bits per slot (TDM/PCM) |
| cfg_channels | input | 5 | Channels per frame (TDM/PCM) |
| cfg_fsync_bits | input | 10 | Sync pulse width in bits (TDM/PCM) |
| cfg_shift | input | 3 | Data offset in half bit periods (TDM/PCM) |
| cfg_sample_bits | input | 6 | Significant bits per sample |
| cfg_bclk_inv | input | 1 | Invert the bit clock |
| cfg_fsync_inv | input | 1 | Invert the frame sync |
| s_valid | input | 1 | Sample on `s_data` is valid |
| s_ready | output | 1 | Block takes a sample this cycle |
| s_data | input | 32 | Left-aligned sample |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky missing-sample flag |

## Verification
Two functions meet in one cycle: the fetch of the next frame's first sample, and the frame wrap. The wrap restarts the sync pulse and the slot counters, while the offset line is still emitting the previous frame's last bits. The case is provoked by running every framing and offsets 0 through 4 for two full frames, so each run crosses the wrap twice. It is judged by comparing every half-bit of `bclk`, `fsync` and `sdata` against a stream computed from the requirements, and by counting that the `s_ready` pulses fall only in second halves.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    typedef enum logic [1:0] {
        FMT_TDM = 2'd0,
        FMT_I2S = 2'd1,
        FMT_LJ  = 2'd2,
        FMT_RJ  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_PAD    = 2'd3
    } slot_st_e;

endpackage

// File: rtl/tdm_tx_timing.sv
module tdm_tx_timing #(
    parameter int FW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [FW-1:0] frame_len,
    input  logic [FW-1:0] slot_len,
    input  logic [FW-1:0] fs_len,
    input  logic          fs_base,
    input  logic          bclk_inv,
    input  logic          fsync_inv,
    output logic          phase,
    output logic [FW-1:0] sbit,
    output logic [FW-1:0] sidx,
    output logic          frame_last,
    output logic          slot_last,
    output logic          bclk,
    output logic          fsync
);

    logic [FW-1:0] bit_q;

    assign frame_last = (bit_q == frame_len - FW'(1));
    assign slot_last  = (sbit == slot_len - FW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= 1'b0;
            bit_q <= '0;
            sbit  <= '0;
            sidx  <= '0;
        end else if (!run) begin
            phase <= 1'b0;
            bit_q <= '0;
            sbit  <= '0;
            sidx  <= '0;
        end else begin
            phase <= ~phase;
            if (phase) begin
                if (frame_last) begin
                    bit_q <= '0;
                    sbit  <= '0;
                    sidx  <= '0;
                end else begin
                    bit_q <= bit_q + FW'(1);
                    if (slot_last) begin
                        sbit <= '0;
                        sidx <= sidx + FW'(1);
                    end else begin
                        sbit <= sbit + FW'(1);
                    end
                end
            end
        end
    end

    always_comb begin
        bclk  = run ? (phase ^ bclk_inv) : bclk_inv;
        fsync = run ? ((bit_q < fs_len) ^ fs_base ^ fsync_inv) : fsync_inv;
    end

    assert_bclk_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (bclk != $past(bclk)));

    assert_fsync_bit_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && phase) |-> $stable(fsync));

endmodule

// File: rtl/tdm_tx_slot.sv
module tdm_tx_slot
    import tdm_tx_pkg::*;
#(
    parameter int FW     = 10,
    parameter int CW     = 5,
    parameter int SW     = 6,
    parameter int SAMP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              phase,
    input  logic              frame_last,
    input  logic              slot_last,
    input  logic [FW-1:0]     sidx,
    input  logic [FW-1:0]     sbit,
    input  logic [CW-1:0]     chans,
    input  logic [FW-1:0]     lead,
    input  logic [SW-1:0]     sbits,
    input  logic              s_valid,
    input  logic [SAMP_W-1:0] s_data,
    output logic              s_ready,
    output slot_st_e          state,
    output logic              raw_bit,
    output logic              underrun
);

    slot_st_e          nxt;
    logic [SAMP_W-1:0] samp;
    logic              running;
    logic              more_ch;
    logic              load_run;
    logic [FW-1:0]     rel;
    logic [SAMP_W-1:0] aligned;

    assign running  = (state == ST_ACTIVE) || (state == ST_PAD);
    assign more_ch  = (sidx + FW'(1)) < FW'(chans);
    assign load_run = running && phase && (frame_last || (slot_last && more_ch));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (enable) nxt = ST_PRIME;
            ST_PRIME:  nxt = enable ? ST_ACTIVE : ST_IDLE;
            ST_ACTIVE,
            ST_PAD: begin
                if (!enable)                            nxt = ST_IDLE;
                else if (load_run)                      nxt = ST_ACTIVE;
                else if (phase && (slot_last || frame_last)) nxt = ST_PAD;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp     <= '0;
            underrun <= 1'b0;
        end else begin
            if (s_ready) samp <= s_valid ? s_data : '0;
            if (!enable)                  underrun <= 1'b0;
            else if (s_ready && !s_valid) underrun <= 1'b1;
        end
    end

    always_comb begin
        s_ready = enable && ((state == ST_PRIME) || load_run);
        rel     = sbit - lead;
        aligned = samp << rel;
        raw_bit = (state == ST_ACTIVE) && (sbit >= lead) &&
                  (rel < FW'(sbits)) && aligned[SAMP_W-1];
    end

    assert_ready_second_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && state != ST_PRIME) |-> phase);

    assert_ready_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

    assert_underrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && enable) |=> underrun);

endmodule

// File: rtl/tdm_tx_delay.sv
module tdm_tx_delay #(
    parameter int MAX_SHIFT = 4,
    parameter int XW        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    input  logic [XW-1:0] shift,
    output logic          dout
);

    logic [MAX_SHIFT-1:0] pipe;
    logic [1:0]           age;

    for (genvar g = 0; g < MAX_SHIFT; g++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pipe[g] <= 1'b0;
            else if (g == 0) pipe[g] <= din;
            else             pipe[g] <= pipe[(g == 0) ? 0 : g-1];
        end
    end

    always_comb begin
        if (shift == '0)                     dout = din;
        else if (shift > XW'(MAX_SHIFT))     dout = pipe[MAX_SHIFT-1];
        else                                 dout = pipe[shift - XW'(1)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    if (MAX_SHIFT >= 2) begin : g_chk
        assert_one_bit_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd3 && shift == XW'(2)) |-> (dout == $past(din, 2)));
    end

endmodule

// File: rtl/tdm_audio_tx.sv
module tdm_audio_tx
    import tdm_tx_pkg::*;
#(
    parameter int MAX_FRAME = 512,
    parameter int MAX_SLOT  = 32,
    parameter int MAX_CH    = 16,
    parameter int MAX_SHIFT = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 enable,
    input  logic [1:0]                           cfg_fmt,
    input  logic [$clog2(MAX_FRAME+1)-1:0]       cfg_frame_bits,
    input  logic [$clog2(MAX_SLOT+1)-1:0]        cfg_slot_bits,
    input  logic [$clog2(MAX_CH+1)-1:0]          cfg_channels,
    input  logic [$clog2(MAX_FRAME+1)-1:0]       cfg_fsync_bits,
    input  logic [$clog2(MAX_SHIFT+1)-1:0]       cfg_shift,
    input  logic [$clog2(MAX_SLOT+1)-1:0]        cfg_sample_bits,
    input  logic                                 cfg_bclk_inv,
    input  logic                                 cfg_fsync_inv,
    input  logic                                 s_valid,
    output logic                                 s_ready,
    input  logic [MAX_SLOT-1:0]                  s_data,
    output logic                                 bclk,
    output logic                                 fsync,
    output logic                                 sdata,
    output logic                                 underrun
);

    localparam int FW = $clog2(MAX_FRAME+1);
    localparam int SW = $clog2(MAX_SLOT+1);
    localparam int CW = $clog2(MAX_CH+1);
    localparam int XW = $clog2(MAX_SHIFT+1);

    slot_st_e      state;
    logic          run, start;
    logic [FW-1:0] half;
    logic [FW-1:0] r_frame, r_slot, r_fsw, r_lead;
    logic [CW-1:0] r_chans;
    logic [XW-1:0] r_shift;
    logic [SW-1:0] r_sbits;
    logic          r_binv, r_finv, r_base;
    logic          phase, frame_last, slot_last, raw_bit, dly_bit;
    logic [FW-1:0] sbit, sidx;

    assign run   = (state == ST_ACTIVE) || (state == ST_PAD);
    assign start = (state == ST_IDLE) && enable;
    assign half  = cfg_frame_bits >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_frame <= FW'(MAX_FRAME); r_slot <= FW'(MAX_SLOT); r_fsw <= FW'(1);
            r_lead  <= '0; r_chans <= CW'(1); r_shift <= '0; r_sbits <= SW'(MAX_SLOT);
            r_binv  <= 1'b0; r_finv <= 1'b0; r_base <= 1'b0;
        end else if (start) begin
            r_frame <= cfg_frame_bits;
            r_sbits <= cfg_sample_bits;
            r_binv  <= cfg_bclk_inv;
            r_finv  <= cfg_fsync_inv;
            if (fmt_e'(cfg_fmt) == FMT_TDM) begin
                r_slot  <= FW'(cfg_slot_bits);
                r_chans <= cfg_channels;
                r_fsw   <= cfg_fsync_bits;
                r_shift <= cfg_shift;
                r_lead  <= '0;
                r_base  <= 1'b0;
            end else begin
                r_slot  <= half;
                r_chans <= CW'(2);
                r_fsw   <= half;
                r_shift <= (fmt_e'(cfg_fmt) == FMT_I2S) ? XW'(2) : '0;
                r_lead  <= (fmt_e'(cfg_fmt) == FMT_RJ) ? half - FW'(cfg_sample_bits) : '0;
                r_base  <= (fmt_e'(cfg_fmt) == FMT_I2S);
            end
        end
    end

    tdm_tx_timing #(.FW(FW)) u_timing (
        .clk(clk), .rst_n(rst_n), .run(run),
        .frame_len(r_frame), .slot_len(r_slot), .fs_len(r_fsw), .fs_base(r_base),
        .bclk_inv(r_binv), .fsync_inv(r_finv),
        .phase(phase), .sbit(sbit), .sidx(sidx),
        .frame_last(frame_last), .slot_last(slot_last),
        .bclk(bclk), .fsync(fsync)
    );

    tdm_tx_slot #(.FW(FW), .CW(CW), .SW(SW), .SAMP_W(MAX_SLOT)) u_slot (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .phase(phase), .frame_last(frame_last), .slot_last(slot_last),
        .sidx(sidx), .sbit(sbit), .chans(r_chans), .lead(r_lead), .sbits(r_sbits),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .state(state), .raw_bit(raw_bit), .underrun(underrun)
    );

    tdm_tx_delay #(.MAX_SHIFT(MAX_SHIFT), .XW(XW)) u_delay (
        .clk(clk), .rst_n(rst_n), .din(raw_bit), .shift(r_shift), .dout(dly_bit)
    );

    assign sdata = (state != ST_IDLE) && dly_bit;

endmodule

// File: tb/sim_tdm_audio_tx.sv
module sim_tdm_audio_tx;

    typedef struct packed {
        logic [1:0] mode;
        logic [9:0] frame;
        logic [5:0] slot;
        logic [4:0] chans;
        logic [9:0] fsw;
        logic [2:0] shift;
        logic [5:0] sbits;
        logic       binv;
        logic       finv;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 10'd64,  6'd16, 5'd4,  10'd1,  3'd0, 6'd16, 1'b0, 1'b0},
        '{2'd0, 10'd256, 6'd32, 5'd8,  10'd1,  3'd1, 6'd24, 1'b0, 1'b0},
        '{2'd0, 10'd128, 6'd24, 5'd3,  10'd8,  3'd2, 6'd20, 1'b1, 1'b0},
        '{2'd0, 10'd32,  6'd16, 5'd2,  10'd3,  3'd3, 6'd16, 1'b0, 1'b1},
        '{2'd0, 10'd96,  6'd32, 5'd16, 10'd32, 3'd4, 6'd32, 1'b0, 1'b0},
        '{2'd1, 10'd64,  6'd16, 5'd5,  10'd1,  3'd4, 6'd24, 1'b0, 1'b0},
        '{2'd2, 10'd48,  6'd16, 5'd1,  10'd2,  3'd3, 6'd16, 1'b0, 1'b1},
        '{2'd3, 10'd64,  6'd16, 5'd1,  10'd2,  3'd1, 6'd20, 1'b1, 1'b0},
        '{2'd0, 10'd512, 6'd32, 5'd16, 10'd1,  3'd0, 6'd32, 1'b0, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
    logic [1:0] cfg_fmt = '0;
    logic [9:0] cfg_frame_bits = 10'd64, cfg_fsync_bits = 10'd1;
    logic [5:0] cfg_slot_bits = 6'd16, cfg_sample_bits = 6'd16;
    logic [4:0] cfg_channels = 5'd1;
    logic [2:0] cfg_shift = '0;
    logic cfg_bclk_inv = 1'b0, cfg_fsync_inv = 1'b0, s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic s_ready, bclk, fsync, sdata, underrun;

    int n_chk = 0, n_fail = 0;
    int fr, sl, ch, fw, sh, ld, sb, served;
    logic vb, vf, base;

    always #5 clk = ~clk;

    tdm_audio_tx u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_fmt(cfg_fmt),
        .cfg_frame_bits(cfg_frame_bits), .cfg_slot_bits(cfg_slot_bits),
        .cfg_channels(cfg_channels), .cfg_fsync_bits(cfg_fsync_bits),
        .cfg_shift(cfg_shift), .cfg_sample_bits(cfg_sample_bits),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_fsync_inv(cfg_fsync_inv),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .bclk(bclk), .fsync(fsync), .sdata(sdata), .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] samp(input int k);
        logic [31:0] v;
        v = 32'(k + 1) * 32'h9E3779B9;
        return v ^ (v >> 13);
    endfunction

    function automatic logic exp_bit(input int t, input bit von);
        int u, b, f, pos, slot, sbit, rel;
        logic [31:0] w;
        u = t - sh;
        if (u < 0) return 1'b0;
        b = u / 2; f = b / fr; pos = b % fr;
        slot = pos / sl; sbit = pos % sl;
        if (slot >= served) return 1'b0;
        rel = sbit - ld;
        if (rel < 0 || rel >= sb || !von) return 1'b0;
        w = samp(f * served + slot);
        return w[31 - rel];
    endfunction

    task automatic run_vec(input vec_t v, input bit von);
        int k, rdy_cnt, bad_rdy, e_b, e_f, e_d, t_b, t_f, t_d, a_d, x_d;
        logic prev_rdy, pos_fs;
        string tag;
        fr = int'(v.frame); sb = int'(v.sbits); vb = v.binv; vf = v.finv;
        if (v.mode == 2'd0) begin
            sl = int'(v.slot); ch = int'(v.chans); fw = int'(v.fsw); sh = int'(v.shift);
            ld = 0; base = 1'b0; tag = "R4 R5 R6 R12 R13";
        end else begin
            sl = fr / 2; ch = 2; fw = fr / 2; sh = (v.mode == 2'd1) ? 2 : 0;
            ld = (v.mode == 2'd3) ? sl - sb : 0; base = (v.mode == 2'd1);
            tag = (v.mode == 2'd1) ? "R7" : (v.mode == 2'd2) ? "R8" : "R9";
        end
        served = (ch < (fr + sl - 1) / sl) ? ch : (fr + sl - 1) / sl;
        @(negedge clk);
        cfg_fmt = v.mode; cfg_frame_bits = v.frame; cfg_slot_bits = v.slot;
        cfg_channels = v.chans; cfg_fsync_bits = v.fsw; cfg_shift = v.shift;
        cfg_sample_bits = v.sbits; cfg_bclk_inv = v.binv; cfg_fsync_inv = v.finv;
        s_valid = von; enable = 1'b1;
        k = 0; prev_rdy = 1'b0; s_data = samp(0);
        rdy_cnt = 0; bad_rdy = 0; e_b = 0; e_f = 0; e_d = 0; t_b = 0; t_f = 0; t_d = 0;
        a_d = 0; x_d = 0;
        for (int t = -1; t < 4 * fr; t++) begin
            @(negedge clk);
            if (prev_rdy) k++;
            s_data = samp(k);
            prev_rdy = s_ready;
            if (s_ready) begin
                rdy_cnt++;
                if (t >= 0 && (t % 2) == 0) bad_rdy++;
            end
            if (t == 0) begin
                // R12: scramble configuration while running
                cfg_fmt = ~v.mode; cfg_frame_bits = 10'd40; cfg_slot_bits = 6'd20;
                cfg_channels = 5'd1; cfg_fsync_bits = 10'd2; cfg_shift = 3'd1;
                cfg_sample_bits = 6'd16; cfg_bclk_inv = ~v.binv; cfg_fsync_inv = ~v.finv;
            end
            if (t >= 0) begin
                pos_fs = (((t / 2) % fr) < fw) ^ base ^ vf;
                if (bclk !== (logic'(t % 2) ^ vb)) begin if (e_b == 0) t_b = t; e_b++; end
                if (fsync !== pos_fs) begin if (e_f == 0) t_f = t; e_f++; end
                if (sdata !== exp_bit(t, von)) begin
                    if (e_d == 0) begin t_d = t; a_d = int'(sdata); x_d = int'(exp_bit(t, von)); end
                    e_d++;
                end
            end
        end
        check(e_b == 0, $sformatf("R2 bclk at half %0d", t_b), e_b, 0);
        check(e_f == 0, $sformatf("R3 %s fsync at half %0d", tag, t_f), e_f, 0);
        check(e_d == 0, $sformatf("%s sdata at half %0d (bit %0d vs %0d)", tag, t_d, a_d, x_d), e_d, 0);
        check(rdy_cnt == 2 * served + 1 && bad_rdy == 0, "R10 R13 ready pulses", rdy_cnt, 2 * served + 1);
        check(underrun === !von, "R11 underrun flag", int'(underrun), int'(!von));
        @(negedge clk);
        enable = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bclk === 1'b0 && fsync === 1'b0, "R1 reset clock/sync", int'({bclk, fsync}), 0);
        check(sdata === 1'b0 && s_ready === 1'b0 && underrun === 1'b0,
              "R1 reset data/ready/underrun", int'({sdata, s_ready, underrun}), 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], 1'b1);
            repeat (3) @(negedge clk);
        end

        // R11: no valid samples -> zeros and sticky flag
        run_vec('{2'd0, 10'd32, 6'd16, 5'd2, 10'd4, 3'd0, 6'd16, 1'b1, 1'b1}, 1'b0);
        // enable fell on the previous negedge; one edge later outputs are idle (R1)
        @(negedge clk);
        check(underrun === 1'b0, "R11 underrun cleared by disable", int'(underrun), 0);
        check(bclk === 1'b1 && fsync === 1'b1, "R1 idle levels follow inversion",
              int'({bclk, fsync}), 3);
        check(sdata === 1'b0 && s_ready === 1'b0, "R1 idle data/ready", int'({sdata, s_ready}), 0);

        finish_run();
    end

endmodule